// File: doc/BRIEF.md
# PWM Periodic Comparison Unit Bank

This block holds eight comparators. All of them watch the counter of the first PWM channel. A unit raises a one-clock match pulse when the counter equals its programmed value. The match must also fall in a selected counter period and, when the counter is center aligned, in the chosen count direction. The pulse can feed an event line, an interrupt flag or a DMA request; that routing lives outside the block.

Each unit has two groups of settings:
- Mode: enable, trigger period and period modulus.
- Value: compare value and direction select.

Each group is written into a pending copy. The pending copy moves into the active copy only when the unit's period divider returns to zero. Software can therefore retune a unit while the counter runs, and a period is never split between old and new settings. A per-unit sticky status bit records every match and is cleared by a status-read strobe.

The counter logic supplies `per_wrap`. It is high during the last clock of each counter period, so the next clock starts a new period.

Top module: `pcb_cmp_bank`

## Requirements
- R1: After reset, every unit is disabled, its settings are zero, and `match` and `status` are all zero.
- R2: A unit matches when it is enabled, no fault is present, and `cnt_val` equals its compare value. The match appears on `match[u]` as a one-clock pulse in the clock after the qualifying inputs.
- R3: When `center_mode` is 1, the direction bit selects the phase in which a match may occur: 1 means while `cnt_down` is 1, and 0 means while `cnt_down` is 0. When `center_mode` is 0, the direction bit has no effect.
- R4: While `fault` is 1, no unit matches.
- R5: Each unit keeps a period divider. It advances by one on each `per_wrap` and returns to 0 after reaching the modulus. Matching is allowed only while the divider equals the trigger value, so a unit fires once every modulus+1 periods. With trigger and modulus both 0, a unit fires every period.
- R6: A write is selected by `wr_unit` and by `wr_sel`: 0 selects the mode group, 1 selects the value group.
  - Mode data layout: bit 0 is enable, bits [PER_W:1] are the trigger value, and bits [2*PER_W:PER_W+1] are the modulus.
  - Value data layout: bits [CNT_W-1:0] are the compare value, and bit CNT_W is the direction bit.
  - Written data takes effect only on a `per_wrap` where the divider returns to 0 (divider at modulus, or unit disabled). Until then the old active settings stay in force.
- R7: A unit pulses at most once per counter period, even when the counter holds the compare value for several clocks.
- R8: When a unit is disabled, or takes new settings, its period divider restarts at 0.
- R9: `status[u]` sets in the same clock as `match[u]` and stays set. `stat_rd` clears all status bits in the next clock, except bits being set by a match in that same clock.
- R10: The units are independent. A write to one unit changes no other unit's behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Current value of the shared channel counter |
| cnt_down | input | 1 | 1 while the counter is decrementing |
| center_mode | input | 1 | 1 when the counter is center aligned |
| per_wrap | input | 1 | High in the last clock of each counter period |
| fault | input | 1 | Fault active on the shared channel |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = mode group, 1 = value group |
| wr_unit | input | $clog2(NUM_UNITS) | Unit addressed by the write |
| wr_data | input | max(CNT_W+1, 2*PER_W+1) | Write data |
| stat_rd | input | 1 | Status read strobe, clears status |
| match | output | NUM_UNITS | One-clock match pulses |
| status | output | NUM_UNITS | Sticky match flags |

## Verification
The bench runs these corner cases against a requirement-level model:
- A unit is armed and then driven through its first period. A design that applied writes at once would fire in that period.
- The counter holds the compare value for three clocks. A design lacking the once-per-period guard would give a three-clock pulse.
- Center-aligned periods are run with both direction settings. The same units are then run in left-aligned mode, where a design that still honoured the direction bit would miss matches.
- A unit is disabled while it is active. It must still fire in the following period on its old settings.
- A period runs under fault, and another runs with the status read held high. Either one exposes a design whose status clears or suppresses in the wrong clock.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  typedef enum logic {
    SEL_MODE  = 1'b0,
    SEL_VALUE = 1'b1
  } pcb_sel_e;

  function automatic int pcb_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pcb_shadow.sv
// Pending/active register pair: writes land in the pending copy and are
// promoted on a load strobe.
module pcb_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         load,
  output logic [W-1:0] active
);

  logic [W-1:0] pend_q, pend_d;
  logic [W-1:0] act_q, act_d;
  logic         full_q, full_d;

  always_comb begin
    pend_d = pend_q;
    full_d = full_q;
    act_d  = act_q;
    if (load && full_q) act_d = pend_q;
    if (load)           full_d = 1'b0;
    if (wr_en) begin
      pend_d = wr_data;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      full_q <= 1'b0;
      act_q  <= '0;
    end else begin
      if (wr_en)          pend_q <= pend_d;
      if (wr_en || load)  full_q <= full_d;
      if (load && full_q) act_q  <= act_d;
    end
  end

  assign active = act_q;

endmodule

// File: rtl/pcb_period_div.sv
// Per-unit period divider: steps on each period wrap, restarts on load.
module pcb_period_div #(
  parameter int PER_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             per_wrap,
  input  logic             restart,
  output logic [PER_W-1:0] prcnt
);

  logic [PER_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (per_wrap) cnt_d = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (per_wrap) cnt_q <= cnt_d;
  end

  assign prcnt = cnt_q;

endmodule

// File: rtl/pcb_unit.sv
// One comparison unit: settings, period divider and match qualification.
module pcb_unit #(
  parameter int CNT_W = 16,
  parameter int PER_W = 4,
  localparam int MODE_W = 2 * PER_W + 1,
  localparam int VAL_W  = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              val_wr,
  input  logic [VAL_W-1:0]  val_wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              cnt_down,
  input  logic              center_mode,
  input  logic              per_wrap,
  input  logic              fault,
  output logic              hit,
  output logic              act_en,
  output logic              act_dir,
  output logic [CNT_W-1:0]  act_cv,
  output logic [PER_W-1:0]  act_ctr,
  output logic [PER_W-1:0]  act_cpr,
  output logic [PER_W-1:0]  prcnt
);

  logic [MODE_W-1:0] mode_act;
  logic [VAL_W-1:0]  val_act;
  logic              load;
  logic              fired_q, fired_d;
  logic              phase_ok;

  assign load = per_wrap && (!act_en || (prcnt >= act_cpr));

  pcb_shadow #(.W(MODE_W)) i_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(mode_wr), .wr_data(mode_wdata),
    .load(load), .active(mode_act)
  );

  pcb_shadow #(.W(VAL_W)) i_val (
    .clk(clk), .rst_n(rst_n), .wr_en(val_wr), .wr_data(val_wdata),
    .load(load), .active(val_act)
  );

  pcb_period_div #(.PER_W(PER_W)) i_div (
    .clk(clk), .rst_n(rst_n), .per_wrap(per_wrap), .restart(load),
    .prcnt(prcnt)
  );

  assign act_en  = mode_act[0];
  assign act_ctr = mode_act[PER_W:1];
  assign act_cpr = mode_act[2*PER_W:PER_W+1];
  assign act_cv  = val_act[CNT_W-1:0];
  assign act_dir = val_act[CNT_W];

  always_comb begin
    phase_ok = !center_mode || (cnt_down == act_dir);
    hit      = act_en && !fault && !fired_q && phase_ok &&
               (cnt_val == act_cv) && (prcnt == act_ctr);
    fired_d  = per_wrap ? 1'b0 : (fired_q || hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                fired_q <= 1'b0;
    else if (per_wrap || hit)  fired_q <= fired_d;
  end

endmodule

// File: rtl/pcb_cmp_bank.sv
// Bank of periodic comparison units sharing one channel counter.
module pcb_cmp_bank #(
  parameter int NUM_UNITS = 8,
  parameter int CNT_W     = 16,
  parameter int PER_W     = 4,
  localparam int UID_W  = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int MODE_W = 2 * PER_W + 1,
  localparam int VAL_W  = CNT_W + 1,
  localparam int DATA_W = pcb_pkg::pcb_max(MODE_W, VAL_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     cnt_val,
  input  logic                 cnt_down,
  input  logic                 center_mode,
  input  logic                 per_wrap,
  input  logic                 fault,
  input  logic                 wr_en,
  input  logic                 wr_sel,
  input  logic [UID_W-1:0]     wr_unit,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 stat_rd,
  output logic [NUM_UNITS-1:0] match,
  output logic [NUM_UNITS-1:0] status
);

  logic [NUM_UNITS-1:0]            hit_vec;
  logic [NUM_UNITS-1:0]            act_en;
  logic [NUM_UNITS-1:0]            act_dir;
  logic [NUM_UNITS-1:0][CNT_W-1:0] act_cv;
  logic [NUM_UNITS-1:0][PER_W-1:0] act_ctr;
  logic [NUM_UNITS-1:0][PER_W-1:0] act_cpr;
  logic [NUM_UNITS-1:0][PER_W-1:0] prcnt;

  logic [NUM_UNITS-1:0] match_q, match_d;
  logic [NUM_UNITS-1:0] status_q, status_d;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic sel_here;
    assign sel_here = wr_en && (wr_unit == UID_W'(u));

    pcb_unit #(.CNT_W(CNT_W), .PER_W(PER_W)) i_unit (
      .clk(clk), .rst_n(rst_n),
      .mode_wr(sel_here && (wr_sel == pcb_pkg::SEL_MODE)),
      .mode_wdata(wr_data[MODE_W-1:0]),
      .val_wr(sel_here && (wr_sel == pcb_pkg::SEL_VALUE)),
      .val_wdata(wr_data[VAL_W-1:0]),
      .cnt_val(cnt_val), .cnt_down(cnt_down), .center_mode(center_mode),
      .per_wrap(per_wrap), .fault(fault),
      .hit(hit_vec[u]),
      .act_en(act_en[u]), .act_dir(act_dir[u]), .act_cv(act_cv[u]),
      .act_ctr(act_ctr[u]), .act_cpr(act_cpr[u]), .prcnt(prcnt[u])
    );
  end

  always_comb begin
    match_d  = hit_vec;
    status_d = (stat_rd ? '0 : status_q) | hit_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q  <= '0;
      status_q <= '0;
    end else begin
      match_q  <= match_d;
      status_q <= status_d;
    end
  end

  assign match  = match_q;
  assign status = status_q;

endmodule

// File: rtl/pcb_cmp_bank_chk.sv
module pcb_cmp_bank_chk #(
  parameter int N     = 8,
  parameter int CNT_W = 16,
  parameter int PER_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [CNT_W-1:0]        cnt_val,
  input logic                    cnt_down,
  input logic                    center_mode,
  input logic                    per_wrap,
  input logic                    fault,
  input logic                    stat_rd,
  input logic [N-1:0]            match,
  input logic [N-1:0]            status,
  input logic [N-1:0]            act_en,
  input logic [N-1:0]            act_dir,
  input logic [N-1:0][CNT_W-1:0] act_cv,
  input logic [N-1:0][PER_W-1:0] act_ctr,
  input logic [N-1:0][PER_W-1:0] act_cpr,
  input logic [N-1:0][PER_W-1:0] prcnt
);

  a_r4_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (match == '0));

  a_r9_status_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (match != '0) |-> ((status & match) == match));

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> ((status & ~match) == '0));

  for (genvar u = 0; u < N; u++) begin : g_u
    a_r2_match_cause: assert property (@(posedge clk) disable iff (!rst_n)
      match[u] |-> $past(act_en[u] && !fault && (cnt_val == act_cv[u])));

    a_r3_phase: assert property (@(posedge clk) disable iff (!rst_n)
      match[u] |-> $past(!center_mode || (cnt_down == act_dir[u])));

    a_r5_trigger_period: assert property (@(posedge clk) disable iff (!rst_n)
      match[u] |-> $past(prcnt[u] == act_ctr[u]));

    a_r8_divider_bound: assert property (@(posedge clk) disable iff (!rst_n)
      act_en[u] |-> (prcnt[u] <= act_cpr[u]));

    a_r6_hold_between_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      !per_wrap |=> ($stable(act_cv[u]) && $stable(act_en[u]) &&
                     $stable(act_dir[u]) && $stable(act_ctr[u])));

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status[u] && !stat_rd) |=> status[u]);
  end

endmodule

bind pcb_cmp_bank pcb_cmp_bank_chk #(
  .N(NUM_UNITS), .CNT_W(CNT_W), .PER_W(PER_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
  .center_mode(center_mode), .per_wrap(per_wrap), .fault(fault),
  .stat_rd(stat_rd), .match(match), .status(status), .act_en(act_en),
  .act_dir(act_dir), .act_cv(act_cv), .act_ctr(act_ctr), .act_cpr(act_cpr),
  .prcnt(prcnt)
);

// File: tb/test_pcb_cmp_bank.sv
`timescale 1ns/1ps
module test_pcb_cmp_bank;

  localparam int N  = 8;
  localparam int CW = 16;
  localparam int PW = 4;
  localparam int DW = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cnt_val;
  logic          cnt_down, center_mode, per_wrap, fault;
  logic          wr_en, wr_sel;
  logic [2:0]    wr_unit;
  logic [DW-1:0] wr_data;
  logic          stat_rd;
  logic [N-1:0]  match, status;

  always #2.5 clk = ~clk;

  pcb_cmp_bank i_pcb_cmp_bank (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
    .center_mode(center_mode), .per_wrap(per_wrap), .fault(fault),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_unit(wr_unit), .wr_data(wr_data),
    .stat_rd(stat_rd), .match(match), .status(status)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string cur_req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard queues
  int           q_stamp[$];
  logic [N-1:0] q_m[$];
  logic [N-1:0] q_s[$];
  string        q_r[$];

  // requirement-level model state
  int m_en[N], m_ctr[N], m_cpr[N], m_cv[N], m_dir[N], m_pc[N], m_fired[N];
  int p_mode_en[N], p_mode_ctr[N], p_mode_cpr[N], p_mode_full[N];
  int p_cv[N], p_dir[N], p_val_full[N];
  logic [N-1:0] m_st;

  // stimulus variables
  logic [CW-1:0] t_cnt = '1;
  logic t_down = 0, t_center = 0, t_wrap = 0, t_fault = 0, t_rd = 0;
  logic t_wr = 0, t_sel = 0;
  int   t_unit = 0;
  logic [DW-1:0] t_data = '0;

  task automatic tick();
    logic [N-1:0] h;
    cnt_val = t_cnt; cnt_down = t_down; center_mode = t_center;
    per_wrap = t_wrap; fault = t_fault; stat_rd = t_rd;
    wr_en = t_wr; wr_sel = t_sel; wr_unit = 3'(t_unit); wr_data = t_data;
    h = '0;
    for (int u = 0; u < N; u++)
      if (m_en[u] != 0 && !t_fault && (int'(t_cnt) == m_cv[u]) &&
          m_pc[u] == m_ctr[u] && (!t_center || int'(t_down) == m_dir[u]) &&
          m_fired[u] == 0)
        h[u] = 1'b1;
    m_st = (t_rd ? '0 : m_st) | h;
    q_stamp.push_back(cyc + 1); q_m.push_back(h); q_s.push_back(m_st);
    q_r.push_back(cur_req);
    for (int u = 0; u < N; u++) begin
      bit ld;
      ld = t_wrap && (m_en[u] == 0 || m_pc[u] == m_cpr[u]);
      m_fired[u] = t_wrap ? 0 : (m_fired[u] | int'(h[u]));
      if (t_wrap) m_pc[u] = ld ? 0 : m_pc[u] + 1;
      if (ld) begin
        if (p_mode_full[u] != 0) begin
          m_en[u] = p_mode_en[u]; m_ctr[u] = p_mode_ctr[u]; m_cpr[u] = p_mode_cpr[u];
        end
        if (p_val_full[u] != 0) begin
          m_cv[u] = p_cv[u]; m_dir[u] = p_dir[u];
        end
        p_mode_full[u] = 0; p_val_full[u] = 0;
      end
      if (t_wr && t_unit == u) begin
        if (!t_sel) begin
          p_mode_en[u] = int'(t_data[0]); p_mode_ctr[u] = int'(t_data[PW:1]);
          p_mode_cpr[u] = int'(t_data[2*PW:PW+1]); p_mode_full[u] = 1;
        end else begin
          p_cv[u] = int'(t_data[CW-1:0]); p_dir[u] = int'(t_data[CW]);
          p_val_full[u] = 1;
        end
      end
    end
    @(posedge clk); #1;
  endtask

  task automatic wr_mode(int u, int en, int ctr, int cpr);
    t_wr = 1; t_sel = 0; t_unit = u;
    t_data = '0;
    t_data[0] = en[0]; t_data[PW:1] = ctr[PW-1:0]; t_data[2*PW:PW+1] = cpr[PW-1:0];
    tick();
    t_wr = 0;
  endtask

  task automatic wr_val(int u, int cv, int dir);
    t_wr = 1; t_sel = 1; t_unit = u;
    t_data = {dir[0], cv[CW-1:0]};
    tick();
    t_wr = 0;
  endtask

  task automatic idle(int n);
    t_cnt = '1; t_wrap = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic run_left(int len, int rep);
    t_center = 0; t_down = 0;
    for (int v = 0; v < len; v++)
      for (int r = 0; r < rep; r++) begin
        t_cnt = CW'(v);
        t_wrap = (v == len - 1) && (r == rep - 1);
        tick();
      end
    t_wrap = 0;
  endtask

  task automatic run_center(int hlf);
    t_center = 1;
    for (int i = 0; i < 2 * hlf; i++) begin
      if (i < hlf) begin t_cnt = CW'(i); t_down = 0; end
      else begin t_cnt = CW'(2 * hlf - i); t_down = 1; end
      t_wrap = (i == 2 * hlf - 1);
      tick();
    end
    t_wrap = 0; t_center = 0; t_down = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (q_stamp.size() > 0 && q_stamp[0] == cyc) begin
      checks += 2;
      if (match !== q_m[0]) begin
        fails++;
        $display("FAIL %s: match=%b expected %b at cycle %0d", q_r[0], match, q_m[0], cyc);
      end
      if (status !== q_s[0]) begin
        fails++;
        $display("FAIL %s: status=%b expected %b at cycle %0d", q_r[0], status, q_s[0], cyc);
      end
      void'(q_stamp.pop_front()); void'(q_m.pop_front());
      void'(q_s.pop_front()); void'(q_r.pop_front());
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    for (int u = 0; u < N; u++) begin
      m_en[u] = 0; m_ctr[u] = 0; m_cpr[u] = 0; m_cv[u] = 0; m_dir[u] = 0;
      m_pc[u] = 0; m_fired[u] = 0; p_mode_en[u] = 0; p_mode_ctr[u] = 0;
      p_mode_cpr[u] = 0; p_mode_full[u] = 0; p_cv[u] = 0; p_dir[u] = 0;
      p_val_full[u] = 0;
    end
    m_st = '0;
    rst_n = 1'b0;
    cnt_val = '1; cnt_down = 0; center_mode = 0; per_wrap = 0; fault = 0;
    wr_en = 0; wr_sel = 0; wr_unit = '0; wr_data = '0; stat_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (match !== '0 || status !== '0) begin
      fails++;
      $display("FAIL R1: match=%b status=%b expected 0", match, status);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;

    cur_req = "R1"; idle(3);

    // arm unit 0; first period must not fire because settings are pending
    cur_req = "R6";
    wr_mode(0, 1, 0, 0); wr_val(0, 5, 0);
    run_left(10, 1);
    cur_req = "R2"; run_left(10, 1); run_left(10, 1);

    // unit 1 fires every third period in the second slot
    cur_req = "R5";
    wr_mode(1, 1, 1, 2); wr_val(1, 3, 0);
    for (int p = 0; p < 8; p++) run_left(10, 1);

    // direction select in center and left alignment
    cur_req = "R3";
    wr_mode(2, 1, 0, 0); wr_val(2, 4, 1);
    wr_mode(3, 1, 0, 0); wr_val(3, 4, 0);
    run_center(8); run_center(8); run_center(8);
    run_left(8, 1); run_left(8, 1);

    // compare value held for several clocks
    cur_req = "R7";
    run_left(10, 3); run_left(10, 3);

    // fault suppresses every unit
    cur_req = "R4";
    t_fault = 1; run_left(10, 1); run_left(10, 1);
    t_fault = 0; run_left(10, 1);

    // status read clears, matching in the same period sets again
    cur_req = "R9";
    t_rd = 1; tick(); t_rd = 0; idle(2);
    t_rd = 1; run_left(10, 1); t_rd = 0; idle(2);

    // disabling unit 0 waits for the boundary; unit 1 reprogrammed
    cur_req = "R8";
    wr_mode(0, 0, 0, 0);
    wr_mode(1, 1, 0, 0);
    run_left(10, 1); run_left(10, 1); run_left(10, 1);

    // last unit, independent of the others
    cur_req = "R10";
    wr_mode(7, 1, 0, 1); wr_val(7, 9, 0);
    for (int p = 0; p < 5; p++) run_left(10, 1);

    idle(3);
    @(negedge clk); @(negedge clk);
    finish_run();
  end

endmodule